// File: doc/BRIEF.md
# Prescaled and Cascaded Timer Counter

This block is an 8-bit up-counter that picks where its count pulses come from. A free-running prescaler runs on the system clock, and each of its bits is a divided clock. A 3-bit source field chooses the source. Three of its codes select a pair of divided clocks, and a one-bit modifier picks one clock from that pair. A fourth code makes the counter follow compare-match events from a neighbouring timer channel, so two channels can be chained into a longer timer. The code for "off" stops counting. The three remaining codes are illegal. They freeze the counter and raise a flag.

A divided clock advances the counter on its falling edge only. The falling edge is found as a one-to-zero change of the matching prescaler bit. The neighbour's strobe is edge-detected, so a strobe that stays high advances the counter once. Two channels that are set to drive each other can therefore stall, but they cannot run away. The counter wraps from its top value to zero and gives a one-cycle overflow pulse when it does.

Top module: `tick_source_counter`

## Requirements
- R1: Source code 000 keeps the count unchanged for either modifier value.
- R2: Source code 001 counts at the system clock divided by 8 when the modifier is 0, and divided by 2 when the modifier is 1.
- R3: Source code 010 counts at the system clock divided by 64 when the modifier is 0, and divided by 128 when the modifier is 1.
- R4: Source code 011 counts at the system clock divided by 1024 when the modifier is 0, and divided by 2048 when the modifier is 1.
- R5: A divided clock of ratio D counts on its falling edge. After reset is released, the k-th count appears at clock edge k·D+1, so after edge N the count is floor((N-1)/D) modulo 256.
- R6: Source code 100 advances the count once, on the edge that first samples the cascade strobe high, and the modifier has no effect. With codes 001 to 011 the strobe has no effect.
- R7: A cascade strobe that stays high advances the count only once, so a stuck or looped cascade leaves the counter frozen.
- R8: Source codes 101, 110 and 111 hold the count. From the following edge they set the illegal-setting flag, and the flag clears one edge after a legal code returns.
- R9: The count wraps from 255 to 0. The overflow output is high for exactly the one cycle that follows that wrap.
- R10: A change of source takes effect at the next edge. It resets neither the prescaler nor the count, so the new divided clock keeps its phase from reset.
- R11: An active-low reset clears the count, the prescaler, the overflow pulse and the illegal-setting flag, whatever code is applied during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| clk_sel | input | 3 | Count source code |
| clk_alt | input | 1 | Modifier that picks the divided clock within a pair |
| casc_match | input | 1 | Compare-match strobe from the neighbouring channel |
| count | output | 8 | Counter value |
| ovf_pulse | output | 1 | One-cycle pulse after a wrap from 255 to 0 |
| sel_bad | output | 1 | Illegal source code flag |

## Verification
Each divided-clock setting is run for a number of cycles chosen so that a counter triggered on the rising edge would end one count apart from a correct one. Tap-index mistakes and edge-polarity mistakes therefore both give wrong final counts. Directed tests switch the source in the middle of a run and check the exact edge of the first count. A design that restarts the prescaler on a change would count late. Another test holds the cascade strobe high, which catches a level-sensitive design because it would run away. The wrap test checks that the overflow pulse lines up with the edge on which the count goes from 255 to 0 and lasts one cycle.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  typedef enum logic [1:0] {
    SRC_OFF,
    SRC_TAP,
    SRC_CASC,
    SRC_BAD
  } src_e;

  // Prescaler bit whose falling edge gives the divided clock.
  // Bit b falls once every 2^(b+1) system clocks.
  function automatic int unsigned tap_of(input logic [1:0] grp, input logic alt);
    int unsigned idx;
    case (grp)
      2'd1:    idx = alt ? 0  : 2;   // /2  or /8
      2'd2:    idx = alt ? 6  : 5;   // /128 or /64
      2'd3:    idx = alt ? 10 : 9;   // /2048 or /1024
      default: idx = 0;
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/tsel_prescaler.sv
module tsel_prescaler #(
  parameter int PRE_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PRE_W-1:0] fall
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] prev_q;

  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      prev_q <= '0;
    end else begin
      pre_q  <= pre_d;
      prev_q <= pre_q;
    end
  end

  // One-cycle enable for each divided clock when its bit goes from 1 to 0
  for (genvar i = 0; i < PRE_W; i++) begin : g_fall
    assign fall[i] = prev_q[i] & ~pre_q[i];
  end

endmodule

// File: rtl/tsel_select.sv
module tsel_select
  import tsel_pkg::*;
#(
  parameter int PRE_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       clk_sel,
  input  logic             clk_alt,
  input  logic             casc_match,
  input  logic [PRE_W-1:0] fall,
  output logic             adv,
  output logic             bad_q
);

  localparam int IDX_W = $clog2(PRE_W);

  src_e             src;
  logic [IDX_W-1:0] tap_idx;
  logic             tap_hit;
  logic             casc_q;
  logic             casc_edge;
  logic             bad_d;

  always_comb begin
    case (clk_sel)
      3'b000:                src = SRC_OFF;
      3'b001, 3'b010, 3'b011: src = SRC_TAP;
      3'b100:                src = SRC_CASC;
      default:               src = SRC_BAD;
    endcase
  end

  always_comb begin
    tap_idx   = IDX_W'(tap_of(clk_sel[1:0], clk_alt));
    tap_hit   = fall[tap_idx];
    casc_edge = casc_match & ~casc_q;
    adv       = ((src == SRC_TAP) & tap_hit) | ((src == SRC_CASC) & casc_edge);
    bad_d     = (src == SRC_BAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      casc_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      casc_q <= casc_match;
      bad_q  <= bad_d;
    end
  end

endmodule

// File: rtl/tsel_count.sv
module tsel_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);

  logic [CNT_W-1:0] cnt_d;
  logic             ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = 1'b0;
    if (adv) begin
      cnt_d = cnt_q + 1'b1;
      ovf_d = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

endmodule

// File: rtl/tick_source_counter.sv
module tick_source_counter #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       clk_sel,
  input  logic             clk_alt,
  input  logic             casc_match,
  output logic [CNT_W-1:0] count,
  output logic             ovf_pulse,
  output logic             sel_bad
);

  logic [PRE_W-1:0] fall;
  logic             adv;

  tsel_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .fall  (fall)
  );

  tsel_select #(.PRE_W(PRE_W)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_sel    (clk_sel),
    .clk_alt    (clk_alt),
    .casc_match (casc_match),
    .fall       (fall),
    .adv        (adv),
    .bad_q      (sel_bad)
  );

  tsel_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .cnt_q (count),
    .ovf_q (ovf_pulse)
  );

endmodule

// File: rtl/tsel_checker.sv
module tsel_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       clk_sel,
  input logic             casc_match,
  input logic [CNT_W-1:0] count,
  input logic             ovf_pulse,
  input logic             sel_bad
);

  assert_hold_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'b000) |=> (count == $past(count)));

  assert_hold_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel[2] && (clk_sel[1:0] != 2'b00)) |=> ((count == $past(count)) && sel_bad));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_sel[2] || (clk_sel[1:0] == 2'b00)) |=> !sel_bad);

  assert_held_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (clk_sel == 3'b100) && casc_match && $past(casc_match))
      |=> (count == $past(count)));

  assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1)));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ((count == '0) && ($past(count) == {CNT_W{1'b1}})));

  assert_ovf_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

endmodule

bind tick_source_counter tsel_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_sel    (clk_sel),
  .casc_match (casc_match),
  .count      (count),
  .ovf_pulse  (ovf_pulse),
  .sel_bad    (sel_bad)
);

// File: tb/tb_tick_source_counter.sv
`timescale 1ns/1ps
module tb_tick_source_counter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] clk_sel;
  logic       clk_alt;
  logic       casc_match;
  logic [7:0] count;
  logic       ovf_pulse;
  logic       sel_bad;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_source_counter dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_sel    (clk_sel),
    .clk_alt    (clk_alt),
    .casc_match (casc_match),
    .count      (count),
    .ovf_pulse  (ovf_pulse),
    .sel_bad    (sel_bad)
  );

  // Each vector: reset, apply the code, run N edges, compare count and flag.
  // Expected count = floor((N-1)/D) mod 256. N is picked so that a
  // rising-edge design would differ by one.
  localparam int NV = 12;
  localparam logic [2:0] V_SEL [NV] = '{3'b000, 3'b000, 3'b001, 3'b001, 3'b010, 3'b010,
                                        3'b011, 3'b011, 3'b101, 3'b110, 3'b111, 3'b001};
  localparam logic       V_ALT [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
                                        1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam int         V_N   [NV] = '{40, 40, 38, 20, 170, 220, 1600, 3500, 100, 100, 100, 520};
  localparam int         V_CNT [NV] = '{0, 0, 4, 9, 2, 1, 1, 1, 0, 0, 0, 3};
  localparam int         V_BAD [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0};
  // requirement tag of each vector: R1 R1 R2 R2 R3 R3 R4 R4 R8 R8 R8 R9
  localparam int         V_REQ [NV] = '{1, 1, 2, 2, 3, 3, 4, 4, 8, 8, 8, 9};

  task automatic check(input int req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] s, input logic a);
    @(negedge clk);
    rst_n = 1'b0;
    casc_match = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    clk_sel = s;
    clk_alt = a;
    rst_n = 1'b1;
  endtask

  task automatic pulse_casc();
    casc_match = 1'b1;
    @(negedge clk);
    casc_match = 1'b0;
    run(2);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R0 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clk_sel = 3'b000;
    clk_alt = 1'b0;
    casc_match = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      do_reset(V_SEL[i], V_ALT[i]);
      run(V_N[i]);
      check(V_REQ[i], "count after run", count, V_CNT[i]);
      check(8, "sel_bad after run", sel_bad, V_BAD[i]);
    end

    // R11: reset in the middle of counting, with an illegal code applied
    do_reset(3'b001, 1'b1);
    run(100);
    rst_n = 1'b0;
    clk_sel = 3'b101;
    run(2);
    check(11, "count in reset", count, 0);
    check(11, "ovf in reset", ovf_pulse, 0);
    check(11, "sel_bad in reset", sel_bad, 0);

    // R5: the first /8 count lands on edge 9
    do_reset(3'b001, 1'b0);
    run(8);
    check(5, "count at edge 8", count, 0);
    run(1);
    check(5, "count at edge 9", count, 1);

    // R9: /2 wrap at edge 513, one-cycle overflow
    do_reset(3'b001, 1'b1);
    run(512);
    check(9, "count before wrap", count, 255);
    check(9, "ovf before wrap", ovf_pulse, 0);
    run(1);
    check(9, "count after wrap", count, 0);
    check(9, "ovf after wrap", ovf_pulse, 1);
    run(1);
    check(9, "ovf next cycle", ovf_pulse, 0);

    // R10: switch from off to /8 after edge 37; prescaler phase kept
    do_reset(3'b000, 1'b0);
    run(37);
    clk_sel = 3'b001;
    run(3);
    check(10, "count at edge 40", count, 0);
    run(1);
    check(10, "count at edge 41", count, 1);
    clk_sel = 3'b000;
    clk_alt = 1'b1;
    run(20);
    check(1, "count held when off", count, 1);

    // R8: illegal code holds the count, flag sets then clears
    do_reset(3'b001, 1'b1);
    run(20);
    check(2, "count before illegal", count, 9);
    clk_sel = 3'b110;
    run(1);
    check(8, "flag one edge after illegal", sel_bad, 1);
    run(10);
    check(8, "count held while illegal", count, 9);
    clk_sel = 3'b001;
    run(1);
    check(8, "flag cleared", sel_bad, 0);

    // R6: cascade pulses counted, modifier ignored
    do_reset(3'b100, 1'b0);
    for (int k = 0; k < 5; k++) begin
      clk_alt = k[0];
      pulse_casc();
    end
    check(6, "cascade count", count, 5);
    // R6: strobe has no effect in a divided-clock mode
    clk_sel = 3'b011;
    clk_alt = 1'b1;
    for (int k = 0; k < 3; k++) pulse_casc();
    check(6, "strobe ignored in tap mode", count, 5);

    // R7: held strobe counts once
    clk_sel = 3'b100;
    casc_match = 1'b1;
    run(30);
    check(7, "held strobe count", count, 6);
    casc_match = 1'b0;
    run(2);
    check(7, "after strobe release", count, 6);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule